// File: doc/BRIEF.md
# Programmable Scanline Interrupt Timer

This block gives line interrupts to a video system that has only a frame interrupt. A prescaler divides the CPU clock into one tick per horizontal line, and a 9-bit line counter advances on every tick. When the counter steps onto a line number that software has programmed, an active-low interrupt is latched. It stays asserted until software acknowledges it.

The block does not lock to the video chip by itself. Software aligns it by issuing a restart command from its frame interrupt handler. After that, reading the counter tells the CPU which line is being drawn. The compare target fires once per frame, on the chosen line. A small byte-wide register port carries all CPU access: staging and committing the target, the interrupt enable, the restart and acknowledge commands, and reading back the count and pending state.

Top module: `line_irq_timer`

## Requirements
- R1: With no restart, the line count advances by exactly one every 228 clock cycles.
- R2: Writing address 3 with bit 0 set clears the prescaler and the line count on the same edge. The count then reads 0 for 228 cycles and reads 1 on the 228th edge after the restart.
- R3: Reading address 0 returns count bits 7..0. Reading address 1 returns count bit 8 in bit 0, with zeros above it.
- R4: When the enable is set and a line tick moves the count onto the committed target, irq_n goes low on that same edge.
- R5: Once low, irq_n stays low until a write to address 3 with bit 1 set. It returns high on the edge of that write. If a new match lands on the same edge, the match wins and irq_n stays low.
- R6: Writing address 0 only stages the low target byte. Writing address 1 commits the target as {data bit 0, staged byte}, and a staged byte by itself never changes which line matches.
- R7: Address 2 bit 0 is the interrupt enable. While it is 0, no match asserts irq_n, and the count keeps advancing. Reading address 2 returns the enable in bit 0 and the pending interrupt in bit 1.
- R8: The count wraps from 511 to 0 on a tick, and a target of 0 matches on that wrap. A restart that brings the count to 0 is not a match.
- R9: After reset, the count is 0, irq_n is high, the enable is 0 and the committed target is 0.
- R10: A match fires only on the tick that enters the target. Staying on the target line after an acknowledge raises no new interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; the line tick is derived from it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe for the register port, one cycle per write |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| irq_n | output | 1 | Active-low line interrupt, latched until acknowledged |

## Verification
A wrong prescaler phase or a lost tick shows up on the count read at address 0 within one line period, about 228 cycles. It stays visible until the next restart, so a reference count kept every clock catches it on the first edge where the two differ. A wrong committed target, a wrong enable or a wrong latch state shows up on irq_n. It appears either on the tick that should have entered the target or on the first cycle after an acknowledge. The long runs through line 256 and through the 511-to-0 wrap expose bit-8 and wrap errors, which short runs never reach.

// File: rtl/lit_pkg.sv
package lit_pkg;

  typedef enum logic [1:0] {
    LIT_A_LINE_LO = 2'd0,
    LIT_A_LINE_HI = 2'd1,
    LIT_A_CTRL    = 2'd2,
    LIT_A_CMD     = 2'd3
  } lit_addr_e;

  localparam int unsigned LIT_CMD_RESTART_BIT = 0;
  localparam int unsigned LIT_CMD_ACK_BIT     = 1;
  localparam int unsigned LIT_CTRL_EN_BIT     = 0;
  localparam int unsigned LIT_STAT_PEND_BIT   = 1;

endpackage

// File: rtl/lit_prescaler.sv
module lit_prescaler #(
  parameter int unsigned CLKS_PER_LINE = 228
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int unsigned PRE_W = $clog2(CLKS_PER_LINE);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_LINE - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             at_last;

  assign at_last = (pre_q == PRE_LAST);
  assign tick    = at_last && !restart;

  always_comb begin
    pre_d = pre_q + PRE_W'(1);
    if (restart || at_last) pre_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/lit_line_counter.sv
module lit_line_counter #(
  parameter int unsigned LINE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              tick,
  input  logic [LINE_W-1:0] target,
  input  logic              irq_en,
  output logic [LINE_W-1:0] line_q,
  output logic              fire
);
  logic [LINE_W-1:0] line_d;
  logic [LINE_W-1:0] line_inc;
  logic              line_ce;

  assign line_inc = line_q + LINE_W'(1);
  assign line_ce  = restart || tick;
  assign fire     = tick && irq_en && (line_inc == target);

  always_comb begin
    line_d = line_q;
    if (restart)   line_d = '0;
    else if (tick) line_d = line_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       line_q <= '0;
    else if (line_ce) line_q <= line_d;
  end
endmodule

// File: rtl/lit_regs.sv
module lit_regs
  import lit_pkg::*;
#(
  parameter int unsigned LINE_W = 9,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [LINE_W-1:0] target,
  output logic              irq_en,
  output logic              restart,
  output logic              ack
);
  localparam int unsigned HI_W = LINE_W - DATA_W;

  logic [DATA_W-1:0] stage_q, stage_d;
  logic [LINE_W-1:0] target_q, target_d;
  logic              en_q, en_d;
  logic              wr_lo, wr_hi, wr_ctrl, wr_cmd;

  assign wr_lo   = reg_wr && (reg_addr == LIT_A_LINE_LO);
  assign wr_hi   = reg_wr && (reg_addr == LIT_A_LINE_HI);
  assign wr_ctrl = reg_wr && (reg_addr == LIT_A_CTRL);
  assign wr_cmd  = reg_wr && (reg_addr == LIT_A_CMD);

  assign restart = wr_cmd && reg_wdata[LIT_CMD_RESTART_BIT];
  assign ack     = wr_cmd && reg_wdata[LIT_CMD_ACK_BIT];

  always_comb begin
    stage_d  = wr_lo   ? reg_wdata : stage_q;
    target_d = wr_hi   ? {reg_wdata[HI_W-1:0], stage_q} : target_q;
    en_d     = wr_ctrl ? reg_wdata[LIT_CTRL_EN_BIT] : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q  <= '0;
      target_q <= '0;
      en_q     <= 1'b0;
    end else begin
      if (wr_lo)   stage_q  <= stage_d;
      if (wr_hi)   target_q <= target_d;
      if (wr_ctrl) en_q     <= en_d;
    end
  end

  assign target = target_q;
  assign irq_en = en_q;
endmodule

// File: rtl/lit_irq_latch.sv
module lit_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic ack,
  output logic pending
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (fire)     pend_d = 1'b1;
    else if (ack) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;
endmodule

// File: rtl/line_irq_timer.sv
module line_irq_timer
  import lit_pkg::*;
#(
  parameter int unsigned CLKS_PER_LINE = 228,
  parameter int unsigned LINE_W        = 9,
  parameter int unsigned DATA_W        = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_n
);
  localparam int unsigned HI_W = LINE_W - DATA_W;

  logic [1:0]        rst_sync_q;
  logic              rst_sync_n;
  logic              tick, restart, ack, fire, irq_en, pending;
  logic [LINE_W-1:0] target, line_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  lit_regs #(.LINE_W(LINE_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .target(target), .irq_en(irq_en),
    .restart(restart), .ack(ack)
  );

  lit_prescaler #(.CLKS_PER_LINE(CLKS_PER_LINE)) u_pre (
    .clk(clk), .rst_n(rst_sync_n), .restart(restart), .tick(tick)
  );

  lit_line_counter #(.LINE_W(LINE_W)) u_line (
    .clk(clk), .rst_n(rst_sync_n), .restart(restart), .tick(tick),
    .target(target), .irq_en(irq_en), .line_q(line_cnt), .fire(fire)
  );

  lit_irq_latch u_irq (
    .clk(clk), .rst_n(rst_sync_n), .fire(fire), .ack(ack), .pending(pending)
  );

  assign irq_n = ~pending;

  always_comb begin
    reg_rdata = '0;
    case (lit_addr_e'(reg_addr))
      LIT_A_LINE_LO: reg_rdata = line_cnt[DATA_W-1:0];
      LIT_A_LINE_HI: reg_rdata[HI_W-1:0] = line_cnt[LINE_W-1:DATA_W];
      LIT_A_CTRL: begin
        reg_rdata[LIT_CTRL_EN_BIT]   = irq_en;
        reg_rdata[LIT_STAT_PEND_BIT] = pending;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/lit_checker.sv
module lit_checker #(
  parameter int unsigned CLKS_PER_LINE = 228,
  parameter int unsigned LINE_W        = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              restart,
  input logic              ack,
  input logic              fire,
  input logic              irq_en,
  input logic              irq_n,
  input logic [LINE_W-1:0] line_cnt,
  input logic [LINE_W-1:0] target
);
  localparam int unsigned GAP_W = $clog2(CLKS_PER_LINE) + 1;
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                gap_q <= '0;
    else if (tick || restart)  gap_q <= '0;
    else                       gap_q <= gap_q + GAP_W'(1);
  end

  a_r1_tick_period: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (gap_q == GAP_W'(CLKS_PER_LINE - 1)));

  a_r2_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (line_cnt == '0));

  a_r4_fall_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(fire));

  a_r4_match_lands_on_target: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (line_cnt == $past(target)));

  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !ack) |=> !irq_n);

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en && irq_n) |=> irq_n);

  a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (line_cnt == '1)) |=> (line_cnt == '0));
endmodule

bind line_irq_timer lit_checker #(
  .CLKS_PER_LINE(CLKS_PER_LINE), .LINE_W(LINE_W)
) u_lit_checker (
  .clk(clk), .rst_n(rst_sync_n), .tick(tick), .restart(restart), .ack(ack),
  .fire(fire), .irq_en(irq_en), .irq_n(irq_n), .line_cnt(line_cnt),
  .target(target)
);

// File: tb/test_line_irq_timer.sv
module test_line_irq_timer;
  localparam int CLK_P = 10;
  localparam int LINE_CLKS = 228;
  localparam int WATCHDOG = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic       irq_n;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference model state
  int m_pre = 0, m_line = 0, m_stage = 0, m_tgt = 0, m_rel = 0;
  bit m_en = 0, m_irq = 0;

  always #(CLK_P/2) clk = ~clk;

  line_irq_timer i_line_irq_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n)
  );

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int exp_read(int a);
    case (a)
      0: return m_line % 256;
      1: return m_line / 256;
      2: return (int'(m_irq) << 1) | int'(m_en);
      default: return 0;
    endcase
  endfunction

  // cycle model, updated on every edge and compared a quarter period later
  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_pre = 0; m_line = 0; m_stage = 0; m_tgt = 0; m_en = 0; m_irq = 0; m_rel = 0;
    end else if (m_rel < 2) begin
      m_rel++;
    end else begin
      bit rs, ak, tk, fr;
      int nl;
      rs = reg_wr && reg_addr == 2'd3 && reg_wdata[0];
      ak = reg_wr && reg_addr == 2'd3 && reg_wdata[1];
      tk = (m_pre == LINE_CLKS - 1) && !rs;
      nl = rs ? 0 : (tk ? (m_line + 1) % 512 : m_line);
      fr = tk && m_en && (nl == m_tgt);
      m_irq = fr ? 1'b1 : (ak ? 1'b0 : m_irq);
      m_line = nl;
      m_pre = (rs || m_pre == LINE_CLKS - 1) ? 0 : m_pre + 1;
      if (reg_wr && reg_addr == 2'd0) m_stage = reg_wdata;
      if (reg_wr && reg_addr == 2'd1) m_tgt = (int'(reg_wdata[0]) << 8) | m_stage;
      if (reg_wr && reg_addr == 2'd2) m_en = reg_wdata[0];
    end
    #(CLK_P/4);
    if (!done) begin
      check("R4/R5/R7 irq_n model", irq_n, !m_irq);
      check("R1/R3 read model", reg_rdata, exp_read(reg_addr));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 8'd0;
  endtask

  task automatic sel(input logic [1:0] a);
    @(negedge clk);
    reg_addr = a;
  endtask

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic wait_irq(int max, output int got);
    got = 0;
    for (int i = 0; i < max; i++) begin
      @(posedge clk);
      #(CLK_P/4);
      if (!irq_n) begin got = 1; break; end
    end
  endtask

  initial begin
    int got;
    // R9: reset state
    cycles(3);
    check("R9 irq_n in reset", irq_n, 1);
    check("R9 count in reset", reg_rdata, 0);
    @(negedge clk); rst_n = 1'b1;
    cycles(4);
    check("R9 count after reset", reg_rdata, 0);
    sel(2'd2); cycles(1);
    check("R9 enable and pending clear", reg_rdata, 0);

    // R2: restart then exact tick timing; R1 spacing
    wr(2'd3, 8'h01);
    cycles(227);
    check("R2 count still 0 before first tick", reg_rdata, 0);
    cycles(1);
    check("R2 count 1 on 228th edge", reg_rdata, 1);
    cycles(LINE_CLKS);
    check("R1 count 2 one line later", reg_rdata, 2);

    // R4/R5/R10: target 3
    wr(2'd0, 8'd3); wr(2'd1, 8'd0); wr(2'd2, 8'd1); wr(2'd3, 8'h01);
    wait_irq(5 * LINE_CLKS, got);
    check("R4 irq fired", got, 1);
    check("R4 count at irq is target", reg_rdata, 3);
    cycles(50);
    check("R5 irq held without ack", irq_n, 0);
    sel(2'd2); cycles(1);
    check("R7 status shows pending and enable", reg_rdata, 3);
    wr(2'd3, 8'h02);
    #(CLK_P/4);
    check("R5 irq released after ack", irq_n, 1);
    cycles(100);
    check("R10 no refire while on target line", irq_n, 1);

    // R6: staged low byte alone leaves target 3 in force
    wr(2'd0, 8'd6); wr(2'd3, 8'h01);
    wait_irq(4 * LINE_CLKS, got);
    check("R6 old target still matches", got, 1);
    check("R6 fired at line 3", reg_rdata, 3);
    wr(2'd3, 8'h02);
    wr(2'd1, 8'd0);
    wr(2'd3, 8'h01);
    wait_irq(4 * LINE_CLKS, got);
    check("R6 new target not reached early", got, 0);
    wait_irq(4 * LINE_CLKS, got);
    check("R6 committed target fires", got, 1);
    check("R6 fired at line 6", reg_rdata, 6);
    wr(2'd3, 8'h02);

    // R7: disabled, counter keeps running
    wr(2'd2, 8'd0); wr(2'd3, 8'h01);
    wait_irq(8 * LINE_CLKS + 10, got);
    check("R7 no irq while disabled", got, 0);
    check("R7 count advanced while disabled", reg_rdata, 8);

    // R3: bit 8 target 256 and high read
    wr(2'd0, 8'h00); wr(2'd1, 8'h01); wr(2'd2, 8'd1); wr(2'd3, 8'h01);
    wait_irq(257 * LINE_CLKS, got);
    check("R3 irq at line 256", got, 1);
    check("R3 low byte at 256", reg_rdata, 0);
    sel(2'd1); cycles(1);
    check("R3 high byte at 256", reg_rdata, 1);
    wr(2'd3, 8'h02);

    // R8: wrap to 0 matches target 0
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wait_irq(257 * LINE_CLKS, got);
    check("R8 irq on wrap", got, 1);
    check("R8 count 0 after wrap", reg_rdata, 0);
    wr(2'd3, 8'h02);
    wr(2'd3, 8'h01);
    cycles(20);
    check("R8 restart to 0 is no match", irq_n, 1);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule